// File: doc/BRIEF.md
# Infrared Pulse-Distance Burst Transmitter

This block turns one 16-bit code word into a complete infrared remote-control burst on a single drive pin. A start strobe latches the code. The block then plays a frame of eighteen symbols: a start symbol, sixteen data symbols (most significant bit first) and a long dark gap. It plays that frame twice, back to back. Each symbol is a dark portion followed by a lit portion. During the lit portion the pin carries a square-wave carrier of about 38 kHz at 50% duty. During the dark portion the pin is held low.

All symbol timing is counted in ticks, and one tick is one carrier period. The carrier period in system clocks is a parameter. It is 112 clocks at the undivided system clock and halves with each clock division, down to 7. The timing unit is 29 ticks. While a burst is in flight, a busy flag and a hardware-enable output are both high, so that the LED driver can be powered only when needed. Strobes that arrive while busy are dropped.

Top module: `ir_frame_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `ir_out`, `busy` and `hw_en` are all 0.
- R2: A `start` pulse while idle latches `code`. In the next cycle `busy` and `hw_en` are 1, and the first tick of the burst begins.
- R3: The start symbol is dark for exactly 1 tick, then lit for 3*UNIT_TICKS-1 ticks.
- R4: Data symbols follow the start symbol, bit 15 first and bit 0 last. A 1 is dark for 2*UNIT_TICKS and then lit for UNIT_TICKS. A 0 is dark for UNIT_TICKS and then lit for UNIT_TICKS.
- R5: The last symbol of each frame is a dark gap of GAP_UNITS*UNIT_TICKS ticks, during which `ir_out` is 0.
- R6: The frame is sent FRAMES times with no pause. From the start of a gap through the first tick of the next start symbol, `ir_out` stays 0 with no pulse.
- R7: The carrier tick counter restarts at 0 when a burst begins. In every lit tick, `ir_out` is 1 for the first CARRIER_CLKS/2 clocks and 0 for the rest of the tick.
- R8: `busy` stays 1 for exactly (total ticks)*CARRIER_CLKS cycles and then returns to 0. `hw_en` equals `busy` in every cycle.
- R9: A `start` pulse while busy has no effect. The code is not re-latched and the burst is not restarted or lengthened.
- R10: Whenever `busy` is 0, `ir_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst request strobe, sampled each rising edge |
| code | input | CODE_W | Code word, latched on an accepted start |
| ir_out | output | 1 | Modulated infrared drive |
| busy | output | 1 | High while a burst is in flight |
| hw_en | output | 1 | Enable for the external LED driver |

## Verification
The assertions assume that `code` only matters in the cycle a start is accepted. They also assume that `start` may be high in any cycle, including during a burst. No further protocol is placed on the inputs. The stimulus holds reset for several cycles before the first strobe. It raises `start` for exactly one cycle per burst, and it injects an extra strobe carrying a different code partway through one burst. It then compares every cycle of the output against a waveform computed arithmetically from the symbol rules, using a reduced carrier period and timing unit so that whole bursts can be swept cycle by cycle.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

    // Width of every tick counter; large enough for 134 units of 29 ticks.
    localparam int TICK_W = 16;
    typedef logic [TICK_W-1:0] tick_cnt_t;

    typedef enum logic [1:0] {
        SYM_START = 2'd0,
        SYM_DATA  = 2'd1,
        SYM_GAP   = 2'd2
    } sym_kind_e;

    typedef struct packed {
        tick_cnt_t dark;   // ticks with the carrier gated off
        tick_cnt_t total;  // full symbol length in ticks
    } sym_shape_t;

    // Shape of one symbol, in ticks, from its kind and data bit.
    function automatic sym_shape_t shape_of(sym_kind_e kind, logic bit_val,
                                            int unsigned unit,
                                            int unsigned gap_units);
        sym_shape_t s;
        case (kind)
            SYM_START: begin
                s.dark  = tick_cnt_t'(1);
                s.total = tick_cnt_t'(3 * unit);
            end
            SYM_DATA: begin
                s.dark  = bit_val ? tick_cnt_t'(2 * unit) : tick_cnt_t'(unit);
                s.total = bit_val ? tick_cnt_t'(3 * unit) : tick_cnt_t'(2 * unit);
            end
            default: begin
                s.dark  = tick_cnt_t'(gap_units * unit);
                s.total = tick_cnt_t'(gap_units * unit);
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
    parameter int CARRIER_CLKS = 112
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           restart,
    input  logic                           run,
    output logic [$clog2(CARRIER_CLKS)-1:0] cnt,
    output logic                           tick_end,
    output logic                           phase_high
);
    localparam int CW = $clog2(CARRIER_CLKS);
    localparam logic [CW-1:0] LAST_C = CW'(CARRIER_CLKS - 1);
    localparam logic [CW-1:0] HALF_C = CW'(CARRIER_CLKS / 2);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
        end
    end

    assign tick_end   = run && (cnt == LAST_C);
    assign phase_high = cnt < HALF_C;

endmodule

// File: rtl/ir_symbol_seq.sv
module ir_symbol_seq
    import ir_tx_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int FRAMES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              sym_done,
    output logic [CODE_W-1:0] code_q,
    output sym_kind_e         kind,
    output logic              data_bit,
    output logic              last_sym
);
    localparam int SYMS = CODE_W + 2;
    localparam int SW   = $clog2(SYMS + 1);
    localparam int FW   = $clog2(FRAMES + 1);
    localparam logic [SW-1:0] SYM_LAST_C   = SW'(SYMS - 1);
    localparam logic [FW-1:0] FRAME_LAST_C = FW'(FRAMES - 1);

    logic [SW-1:0] sym_q;
    logic [FW-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            sym_q   <= '0;
            frame_q <= '0;
        end else if (load) begin
            code_q  <= code_in;
            sym_q   <= '0;
            frame_q <= '0;
        end else if (sym_done) begin
            if (sym_q == SYM_LAST_C) begin
                sym_q   <= '0;
                frame_q <= frame_q + 1'b1;
            end else begin
                sym_q <= sym_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (sym_q == '0)              kind = SYM_START;
        else if (sym_q == SYM_LAST_C) kind = SYM_GAP;
        else                          kind = SYM_DATA;
    end

    // Symbol 1 carries the top bit, symbol CODE_W carries bit 0.
    always_comb begin
        data_bit = 1'b0;
        for (int i = 0; i < CODE_W; i++) begin
            if (sym_q == SW'(i + 1)) data_bit = code_q[CODE_W-1-i];
        end
    end

    assign last_sym = (sym_q == SYM_LAST_C) && (frame_q == FRAME_LAST_C);

endmodule

// File: rtl/ir_envelope_timer.sv
module ir_envelope_timer
    import ir_tx_pkg::*;
#(
    parameter int UNIT_TICKS = 29,
    parameter int GAP_UNITS  = 134
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      tick_end,
    input  sym_kind_e kind,
    input  logic      data_bit,
    output logic      env_on,
    output logic      sym_done
);
    sym_shape_t shape;
    tick_cnt_t  tick_q;

    assign shape    = shape_of(kind, data_bit, UNIT_TICKS, GAP_UNITS);
    assign sym_done = tick_end && (tick_q == shape.total - 1'b1);
    assign env_on   = tick_q >= shape.dark;

    always_ff @(posedge clk) begin
        if (rst || load || sym_done) begin
            tick_q <= '0;
        end else if (tick_end) begin
            tick_q <= tick_q + 1'b1;
        end
    end

endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
    import ir_tx_pkg::*;
#(
    parameter int CARRIER_CLKS = 112,
    parameter int UNIT_TICKS   = 29,
    parameter int GAP_UNITS    = 134,
    parameter int FRAMES       = 2,
    parameter int CODE_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              ir_out,
    output logic              busy,
    output logic              hw_en
);
    localparam int CW = $clog2(CARRIER_CLKS);

    logic              accept;
    logic              tick_end;
    logic              phase_high;
    logic [CW-1:0]     carrier_cnt;
    logic [CODE_W-1:0] code_q;
    sym_kind_e         cur_kind;
    logic              data_bit;
    logic              last_sym;
    logic              env_on;
    logic              sym_done;
    logic              burst_end;

    assign accept    = start && !busy;
    assign burst_end = busy && sym_done && last_sym;

    ir_carrier_gen #(
        .CARRIER_CLKS(CARRIER_CLKS)
    ) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .restart   (accept),
        .run       (busy),
        .cnt       (carrier_cnt),
        .tick_end  (tick_end),
        .phase_high(phase_high)
    );

    ir_symbol_seq #(
        .CODE_W(CODE_W),
        .FRAMES(FRAMES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .code_in (code),
        .sym_done(sym_done),
        .code_q  (code_q),
        .kind    (cur_kind),
        .data_bit(data_bit),
        .last_sym(last_sym)
    );

    ir_envelope_timer #(
        .UNIT_TICKS(UNIT_TICKS),
        .GAP_UNITS (GAP_UNITS)
    ) u_env (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .tick_end(tick_end),
        .kind    (cur_kind),
        .data_bit(data_bit),
        .env_on  (env_on),
        .sym_done(sym_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            hw_en <= 1'b0;
        end else if (accept) begin
            busy  <= 1'b1;
            hw_en <= 1'b1;
        end else if (burst_end) begin
            busy  <= 1'b0;
            hw_en <= 1'b0;
        end
    end

    assign ir_out = busy && env_on && phase_high;

endmodule

// File: rtl/ir_frame_tx_chk.sv
module ir_frame_tx_chk
    import ir_tx_pkg::*;
#(
    parameter int CARRIER_CLKS = 112,
    parameter int CODE_W       = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           start,
    input logic                           busy,
    input logic                           hw_en,
    input logic                           ir_out,
    input logic [CODE_W-1:0]              code_q,
    input logic [$clog2(CARRIER_CLKS)-1:0] carrier_cnt,
    input sym_kind_e                      cur_kind
);
    localparam int CW = $clog2(CARRIER_CLKS);
    localparam logic [CW-1:0] HALF_C = CW'(CARRIER_CLKS / 2);

    a_r10_idle_dark: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !ir_out);

    a_r8_enable_follows_busy: assert property (@(posedge clk) disable iff (rst)
        hw_en == busy);

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r9_code_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(code_q));

    a_r7_carrier_restart: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (carrier_cnt == '0));

    a_r7_second_half_low: assert property (@(posedge clk) disable iff (rst)
        (busy && carrier_cnt >= HALF_C) |-> !ir_out);

    a_r5_gap_dark: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_kind == SYM_GAP) |-> !ir_out);

endmodule

bind ir_frame_tx ir_frame_tx_chk #(
    .CARRIER_CLKS(CARRIER_CLKS),
    .CODE_W      (CODE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .hw_en      (hw_en),
    .ir_out     (ir_out),
    .code_q     (code_q),
    .carrier_cnt(carrier_cnt),
    .cur_kind   (cur_kind)
);

// File: tb/test_ir_frame_tx.sv
module test_ir_frame_tx;
    localparam int P  = 4;
    localparam int U  = 3;
    localparam int G  = 5;
    localparam int F  = 2;
    localparam int CW = 16;
    localparam int MAXT = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] code = '0;
    logic          ir_out, busy, hw_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Expected per-tick envelope and category (0 start dark, 1 start lit,
    // 2 data, 3 final gap, 4 inter-frame dark joint).
    bit env_e [MAXT];
    int cat_e [MAXT];
    int ntick;

    ir_frame_tx #(
        .CARRIER_CLKS(P), .UNIT_TICKS(U), .GAP_UNITS(G),
        .FRAMES(F), .CODE_W(CW)
    ) i_ir_frame_tx (
        .clk(clk), .rst(rst), .start(start), .code(code),
        .ir_out(ir_out), .busy(busy), .hw_en(hw_en)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic add_ticks(input int n, input bit lit, input int cat);
        for (int i = 0; i < n; i++) begin
            env_e[ntick] = lit;
            cat_e[ntick] = cat;
            ntick++;
        end
    endtask

    task automatic build(input logic [CW-1:0] c);
        ntick = 0;
        for (int f = 0; f < F; f++) begin
            add_ticks(1, 1'b0, (f == 0) ? 0 : 4);
            add_ticks(3*U - 1, 1'b1, 1);
            for (int b = CW - 1; b >= 0; b--) begin
                if (c[b]) begin
                    add_ticks(2*U, 1'b0, 2);
                    add_ticks(U, 1'b1, 2);
                end else begin
                    add_ticks(U, 1'b0, 2);
                    add_ticks(U, 1'b1, 2);
                end
            end
            add_ticks(G*U, 1'b0, (f == F - 1) ? 3 : 4);
        end
    endtask

    // Plays one burst of code c; if inject_at >= 0 a stray start carrying
    // ~c is raised for one cycle at that cycle offset.
    task automatic run_burst(input logic [CW-1:0] c, input int inject_at);
        int e_start, e_data, e_gap, e_join, e_car, e_busy, first_bad;
        int total;
        e_start = 0; e_data = 0; e_gap = 0; e_join = 0; e_car = 0; e_busy = 0;
        first_bad = -1;
        build(c);
        total = ntick * P;
        code  = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        code  = ~c;
        check(busy && hw_en, "R2 busy/hw_en after start", {busy, hw_en}, 3);
        for (int k = 0; k < total; k++) begin
            int t, ph, cat;
            bit exp_o;
            if (k > 0) @(negedge clk);
            if (k == inject_at) start = 1'b1;
            else start = 1'b0;
            t   = k / P;
            ph  = k % P;
            cat = cat_e[t];
            exp_o = env_e[t] && (ph < P/2);
            if (!busy || hw_en != busy) e_busy++;
            if (ir_out != exp_o) begin
                if (first_bad < 0) first_bad = k;
                if (env_e[t] && ph >= P/2) e_car++;
                else if (cat == 0 || cat == 1) e_start++;
                else if (cat == 2) e_data++;
                else if (cat == 3) e_gap++;
                else e_join++;
            end
        end
        @(negedge clk);
        start = 1'b0;
        check(e_start == 0, "R3 start symbol shape", e_start, 0);
        check(e_data == 0, "R4 data symbol shapes, MSB first", e_data, 0);
        check(e_gap == 0, "R5 final gap dark", e_gap, 0);
        check(e_join == 0, "R6 frame repeat and dark joint", e_join, 0);
        check(e_car == 0, "R7 carrier half-period low", e_car, 0);
        check(e_busy == 0, "R8 busy/hw_en held through burst", e_busy, 0);
        check(!busy && !hw_en, "R8 busy ends after last tick", {busy, hw_en}, 0);
        check(!ir_out, "R10 output low once idle", ir_out, 0);
        if (inject_at >= 0)
            check(first_bad < 0 && !busy, "R9 start during burst ignored", first_bad, -1);
        repeat (3) begin
            @(negedge clk);
            check(!ir_out && !busy, "R10 idle output low", ir_out, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!ir_out && !busy && !hw_en, "R1 outputs during reset",
              {ir_out, busy, hw_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!ir_out && !busy && !hw_en, "R1 outputs after reset",
              {ir_out, busy, hw_en}, 0);
        run_burst(16'h0000, -1);
        run_burst(16'hFFFF, -1);
        run_burst(16'hA5C3, -1);
        run_burst(16'h8001, 37);
        run_burst(16'h5000, -1);
        run_burst(16'h50FA, P * 70 + 1);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule